// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between four external interrupt request pins and an interrupt controller. It brings each pin into the local clock domain, applies a per-pin sensitivity setting, and presents one pending flag per pin. In the chip the four pins are known as request lines 1, 2, 3 and 6. On the ports and in the status word they are channels 0 to 3, in that order.

Each channel has two settings in a 16-bit control word. The first picks level or edge sensitivity. The second picks active-high or active-low polarity. In level mode the pending flag follows the synchronized pin, and software cannot remove it. In edge mode a qualifying transition sets a sticky flag. That flag stays set until software writes a 1 to the channel's bit in the status word.

Both words sit behind a single-cycle register port. A write takes effect at the clock edge on which it is presented. A read is combinational from the address.

Top module: `extirq_cond`

## Requirements
- R1: After reset the control word reads 0x0000 (all channels level-sensitive, active-low). With all pins held high, the status word reads 0x0000 and `irq_pend_o` is 0.
- R2: Control word (reg_addr=0) layout: polarity of channel k at bit 15-k, edge select of channel k at bit 11-k (k=0..3). A polarity of 1 means active-high and 0 means active-low. An edge select of 1 means edge mode and 0 means level mode. Bits 7..0 ignore writes and read as 0.
- R3: In level mode with active-low polarity, the pending flag is 1 while the pin is low. It appears two clock edges after the pin changes and clears two edges after the pin returns high.
- R4: In level mode with active-high polarity, the pending flag is 1 while the pin is high.
- R5: In edge mode with active-low polarity, a high-to-low pin transition sets the pending flag three clock edges later. The flag stays set after the pin returns high.
- R6: In edge mode with active-high polarity, a low-to-high transition sets the flag, and a high-to-low transition does not.
- R7: Writing the status word (reg_addr=1) with bit k = 1 clears channel k's edge flag at that clock edge. Bits written as 0 leave their channels unchanged.
- R8: A status write of 1 has no effect on a channel in level mode. Its flag still follows the pin.
- R9: If a qualifying edge reaches the flag in the same cycle as a clearing write to that channel, the flag stays set.
- R10: A control write that changes a channel's mode or polarity clears that channel's edge flag. The change itself does not produce a false edge.
- R11: The status word reads the four pending flags in bits 3..0 (channel k in bit k), with bits 15..4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous external request pins, channel k on bit k |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq_pend_o | output | 4 | Pending flag per channel |

## Verification
Each channel is driven with pulses under all four mode and polarity combinations. Level pulses show that the flag follows the pin and cannot be cleared. Edge pulses in both directions show which transition is qualifying and that the flag survives the pin's return. Status writes with foreign bits, zero bits and the channel's own bit separate a correct clear from cross-channel effects. A clear timed onto the capture cycle and a settings change made while a flag is held cover the two priority cases.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   // per-channel sensitivity setting
   typedef struct packed {
      logic pol;        // 1: active high / rising, 0: active low / falling
      logic edge_mode;  // 1: edge captured, 0: level follows pin
   } chan_cfg_t;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
   import extirq_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int REG_W    = 16,
   parameter int POL_MSB  = 15,
   parameter int EDGE_MSB = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wen_i,
   input  logic                    addr_i,
   input  logic [REG_W-1:0]        wdata_i,
   input  logic [NUM_CH-1:0]       pend_i,
   output logic [REG_W-1:0]        rdata_o,
   output chan_cfg_t [NUM_CH-1:0]  cfg_o,
   output logic [NUM_CH-1:0]       chg_o,
   output logic [NUM_CH-1:0]       clr_o
);

   function automatic logic [REG_W-1:0] calc_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         m[POL_MSB-k]  = 1'b1;
         m[EDGE_MSB-k] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [REG_W-1:0] WR_MASK = calc_mask();

   logic [REG_W-1:0] cfg_q;
   logic             ctrl_wr;
   logic             stat_wr;

   assign ctrl_wr = wen_i && (addr_i == ADDR_CTRL);
   assign stat_wr = wen_i && (addr_i == ADDR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (ctrl_wr) begin
         cfg_q <= wdata_i & WR_MASK;
      end
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign cfg_o[k].pol       = cfg_q[POL_MSB-k];
      assign cfg_o[k].edge_mode = cfg_q[EDGE_MSB-k];
      assign chg_o[k] = ctrl_wr &&
                        ((wdata_i[POL_MSB-k]  != cfg_q[POL_MSB-k]) ||
                         (wdata_i[EDGE_MSB-k] != cfg_q[EDGE_MSB-k]));
      assign clr_o[k] = stat_wr && wdata_i[k];
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_CTRL) begin
         rdata_o = cfg_q;
      end else begin
         rdata_o[NUM_CH-1:0] = pend_i;
      end
   end

   // R2
   ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (cfg_q == ($past(wdata_i) & WR_MASK)));

endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
   import extirq_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      s_i,
   input  chan_cfg_t cfg_i,
   input  logic      chg_i,
   input  logic      clr_i,
   output logic      pend_o
);

   logic prev_q;
   logic latch_q;
   logic edge_hit;
   logic level_act;

   assign edge_hit  = cfg_i.edge_mode &&
                      (cfg_i.pol ? (s_i && !prev_q) : (!s_i && prev_q));
   assign level_act = (s_i == cfg_i.pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= RST_VAL;
         latch_q <= 1'b0;
      end else begin
         prev_q <= s_i;
         if (chg_i) begin
            latch_q <= 1'b0;
         end else if (edge_hit) begin
            latch_q <= 1'b1;
         end else if (clr_i) begin
            latch_q <= 1'b0;
         end
      end
   end

   assign pend_o = cfg_i.edge_mode ? latch_q : level_act;

   // R5
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.edge_mode && latch_q && !clr_i && !chg_i) |=> latch_q);

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !chg_i && (s_i == $past(s_i))) |=> !latch_q);

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.edge_mode && cfg_i.pol && s_i && !$past(s_i) && !chg_i) |=> latch_q);

   // R8
   level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_i.edge_mode |-> !latch_q);

   // R10
   cfgchg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_i |=> !latch_q);

endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
   import extirq_pkg::*;
#(
   parameter int   NUM_CH      = 4,
   parameter int   REG_W       = 16,
   parameter int   POL_MSB     = 15,
   parameter int   EDGE_MSB    = 11,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   input  logic              reg_wen,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [NUM_CH-1:0] irq_pend_o
);

   if (NUM_CH < 1 || NUM_CH > REG_W) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (POL_MSB >= REG_W || EDGE_MSB - NUM_CH + 1 < NUM_CH) begin : g_bad_pos
      $error("field positions do not fit the control word");
   end
   if (POL_MSB - NUM_CH + 1 <= EDGE_MSB) begin : g_bad_overlap
      $error("polarity and edge fields overlap");
   end

   chan_cfg_t [NUM_CH-1:0] cfg;
   logic [NUM_CH-1:0]      chg;
   logic [NUM_CH-1:0]      clr;
   logic [NUM_CH-1:0]      sync_s;

   extirq_regs #(
      .NUM_CH   (NUM_CH),
      .REG_W    (REG_W),
      .POL_MSB  (POL_MSB),
      .EDGE_MSB (EDGE_MSB)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_i   (reg_wen),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .pend_i  (irq_pend_o),
      .rdata_o (reg_rdata),
      .cfg_o   (cfg),
      .chg_o   (chg),
      .clr_o   (clr)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      extirq_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (PIN_IDLE)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[k]),
         .q_o   (sync_s[k])
      );

      extirq_chan #(
         .RST_VAL (PIN_IDLE)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .s_i    (sync_s[k]),
         .cfg_i  (cfg[k]),
         .chg_i  (chg[k]),
         .clr_i  (clr[k]),
         .pend_o (irq_pend_o[k])
      );
   end

endmodule

// File: tb/tb_extirq_cond.sv
`timescale 1ns/1ps
module tb_extirq_cond;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_i = 4'hF;
   logic        reg_wen = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  irq_pend_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   extirq_cond dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_i),
      .reg_wen    (reg_wen),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_pend_o (irq_pend_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_wen = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic a, output logic [15:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic restore();
      pin_i = 4'hF;
      wr(1'b0, 16'h0000);
      tick(3);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(1'b0, d);
      chk(d == 16'h0000, "R1 ctrl reset", d, 0);
      rd(1'b1, d);
      chk(d == 16'h0000, "R1 status reset", d, 0);
      chk(irq_pend_o == 4'h0, "R1 pend reset", irq_pend_o, 0);
   endtask

   task automatic t_ctrl();
      logic [15:0] d;
      wr(1'b0, 16'hFFFF);
      rd(1'b0, d);
      chk(d == 16'hFF00, "R2 writable bits", d, 16'hFF00);
      wr(1'b0, 16'h00FF);
      rd(1'b0, d);
      chk(d == 16'h0000, "R2 low bits ignored", d, 0);
      restore();
   endtask

   task automatic t_level_low();
      logic [15:0] d;
      pin_i[0] = 1'b0;
      tick(1);
      chk(irq_pend_o[0] == 1'b0, "R3 sync latency", irq_pend_o[0], 0);
      tick(1);
      chk(irq_pend_o[0] == 1'b1, "R3 level low asserted", irq_pend_o[0], 1);
      rd(1'b1, d);
      chk(d == 16'h0001, "R11 status bit0", d, 1);
      wr(1'b1, 16'h000F);
      chk(irq_pend_o[0] == 1'b1, "R8 level not cleared", irq_pend_o[0], 1);
      pin_i[0] = 1'b1;
      tick(2);
      chk(irq_pend_o[0] == 1'b0, "R3 level released", irq_pend_o[0], 0);
      restore();
   endtask

   task automatic t_level_high();
      wr(1'b0, 16'h2000);
      chk(irq_pend_o[2] == 1'b1, "R4 active high with pin high", irq_pend_o[2], 1);
      pin_i[2] = 1'b0;
      tick(2);
      chk(irq_pend_o[2] == 1'b0, "R4 active high with pin low", irq_pend_o[2], 0);
      restore();
   endtask

   task automatic t_edge_fall();
      logic [15:0] d;
      wr(1'b0, 16'h0400);
      tick(2);
      pin_i[1] = 1'b0;
      tick(2);
      chk(irq_pend_o[1] == 1'b0, "R5 not yet captured", irq_pend_o[1], 0);
      tick(1);
      chk(irq_pend_o[1] == 1'b1, "R5 falling captured", irq_pend_o[1], 1);
      pin_i[1] = 1'b1;
      tick(4);
      chk(irq_pend_o[1] == 1'b1, "R5 sticky after release", irq_pend_o[1], 1);
      rd(1'b1, d);
      chk(d == 16'h0002, "R11 status bit1", d, 2);
      wr(1'b1, 16'h0001);
      chk(irq_pend_o[1] == 1'b1, "R7 other bit no clear", irq_pend_o[1], 1);
      wr(1'b1, 16'h0000);
      chk(irq_pend_o[1] == 1'b1, "R7 zero write no clear", irq_pend_o[1], 1);
      wr(1'b1, 16'h0002);
      chk(irq_pend_o[1] == 1'b0, "R7 own bit clears", irq_pend_o[1], 0);
      restore();
   endtask

   task automatic t_edge_rise();
      wr(1'b0, 16'h1100);
      tick(2);
      pin_i[3] = 1'b0;
      tick(4);
      chk(irq_pend_o[3] == 1'b0, "R6 falling ignored", irq_pend_o[3], 0);
      pin_i[3] = 1'b1;
      tick(3);
      chk(irq_pend_o[3] == 1'b1, "R6 rising captured", irq_pend_o[3], 1);
      // R9: rising edge reaches the flag on the same edge as a clear
      pin_i[3] = 1'b0;
      wr(1'b1, 16'h0008);
      tick(3);
      chk(irq_pend_o[3] == 1'b0, "R7 cleared before race", irq_pend_o[3], 0);
      pin_i[3] = 1'b1;
      tick(2);
      wr(1'b1, 16'h0008);
      chk(irq_pend_o[3] == 1'b1, "R9 edge beats clear", irq_pend_o[3], 1);
      wr(1'b1, 16'h0008);
      chk(irq_pend_o[3] == 1'b0, "R9 later clear works", irq_pend_o[3], 0);
      restore();
   endtask

   task automatic t_cfg_change();
      wr(1'b0, 16'h0400);
      tick(2);
      pin_i[1] = 1'b0;
      tick(3);
      pin_i[1] = 1'b1;
      tick(3);
      chk(irq_pend_o[1] == 1'b1, "R10 setup pending", irq_pend_o[1], 1);
      wr(1'b0, 16'h4400);
      chk(irq_pend_o[1] == 1'b0, "R10 change flushes", irq_pend_o[1], 0);
      tick(4);
      chk(irq_pend_o[1] == 1'b0, "R10 no false edge", irq_pend_o[1], 0);
      // flip polarity while pin sits low: no capture either
      pin_i[1] = 1'b0;
      tick(3);
      wr(1'b0, 16'h0400);
      tick(4);
      chk(irq_pend_o[1] == 1'b0, "R10 polarity flip no edge", irq_pend_o[1], 0);
      restore();
   endtask

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_ctrl();
      t_level_low();
      t_level_high();
      t_edge_fall();
      t_edge_rise();
      t_cfg_change();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule